// File: doc/BRIEF.md
# Mode-Selectable FIR Filter with Paired-Tap Multipliers

This block is a direct-form FIR filter. Each output is the sum, over all taps, of a stored coefficient times the matching delayed input sample: O(m) = sum for i = 0..L-1 of H(i)·S(m-i), with L = 35 by default. Samples arrive on a stream qualified by a valid bit, coefficients are loaded through a simple address/data/write-enable port while the filter is idle, and a one-bit mode input picks how the products are formed.

In the wide mode every tap has its own 8x8 signed multiplier. In the split mode each operand keeps only its upper four bits, and every multiplier forms two 4x4 products at once, so taps 2k and 2k+1 share lane k. Only ceil(L/2) = 18 lanes then do work and the remaining lanes have their operands isolated to zero. The lane products pass through a registered adder tree into a wide accumulator, and the sum is rounded and saturated back to an 8-bit result that comes out with a valid strobe after a fixed latency.

Top module: `fir_dual_product`

## Requirements
- R1: After reset out_valid is low, out_sample is zero, every coefficient is zero and every delay-line entry is zero.
- R2: With coef_we high, coef_data is stored at clock edge as the coefficient of tap coef_addr (0..34); tap 0 weights the newest accepted sample and tap i the sample accepted i valid cycles earlier.
- R3: A write with coef_addr in 35..63 changes no coefficient.
- R4: The delay line advances only on cycles with in_valid high; each accepted sample yields exactly one output with out_valid high, in order, and idle cycles neither shift the line nor produce an output.
- R5: With default parameters out_valid for a sample goes high on the eighth rising edge after the edge that accepts it.
- R6: With mode = 0, the sum is the exact sum of the 35 signed 8x8 products of coefficient and sample, both two's complement.
- R7: With mode = 1, each sample and coefficient is reduced to its signed bits [7:4]; the sum is the sum over taps of the 4x4 products scaled by 256; lane k serves taps 2k and 2k+1, the missing partner of tap 34 counts as zero, and lanes 18..34 contribute zero.
- R8: The output is (sum + 64) shifted arithmetically right by 7, i.e. rounded half toward plus infinity.
- R9: A rounded value above 127 gives 127 and one below -128 gives -128; the sum itself never wraps for any operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample on in_sample is accepted this cycle |
| in_sample | input | 8 | Signed input sample |
| mode | input | 1 | 0 = one 8x8 product per lane, 1 = two 4x4 products per lane |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 6 | Tap index of the coefficient write |
| coef_data | input | 8 | Signed coefficient value |
| out_valid | output | 1 | out_sample carries a new result |
| out_sample | output | 8 | Signed, rounded and saturated filter output |

## Verification
The assertions assume that mode and the coefficients stay constant while any accepted sample is still inside the pipeline, since the product stage reads both directly; the stimulus therefore changes them only after an idle flush longer than the latency. They also assume reset is held for at least two clock edges so the internal synchronised reset clears every stage. The bench sweeps all 256 sample values in both modes under several coefficient sets, including extremes that drive the rounding and saturation boundaries, and inserts idle gaps to exercise the hold behaviour.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic {
    MODE_WIDE  = 1'b0,
    MODE_SPLIT = 1'b1
  } mul_mode_e;
endpackage

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
  parameter int NTAPS = 35,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] taps [NTAPS]
);
  logic [DW-1:0] taps_d [NTAPS];
  logic [DW-1:0] taps_q [NTAPS];

  always_comb begin
    taps_d[0] = din;
    for (int i = 1; i < NTAPS; i++) taps_d[i] = taps_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) taps_q[i] <= '0;
    end else if (shift_en) begin
      taps_q <= taps_d;
    end
  end

  assign taps = taps_q;

  // R4: the newest entry takes the accepted sample, the oldest takes its neighbour
  a_r4_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (taps_q[0] == $past(din)) && (taps_q[NTAPS-1] == $past(taps_q[NTAPS-2])));
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(taps_q[0]) && $stable(taps_q[NTAPS-1]));
endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int NTAPS = 35,
  parameter int DW    = 8,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] coef [NTAPS]
);
  logic [DW-1:0] coef_q [NTAPS];
  logic          hit    [NTAPS];

  for (genvar i = 0; i < NTAPS; i++) begin : g_slot
    assign hit[i] = we && (addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      coef_q[i] <= '0;
      else if (hit[i]) coef_q[i] <= wdata;
    end

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == AW'(i)) |=> coef_q[i] == $past(wdata));
    a_r3_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (we && {1'b0, addr} >= (AW+1)'(NTAPS)) |=> $stable(coef_q[i]));
  end

  assign coef = coef_q;
endmodule

// File: rtl/fir_mac_lane.sv
module fir_mac_lane #(
  parameter int DW = 8,
  parameter int PW = 2*DW + 1
) (
  input  fir_pkg::mul_mode_e  mode,
  input  logic                en,
  input  logic [DW-1:0]       sa,
  input  logic [DW-1:0]       ha,
  input  logic [DW-1:0]       sb,
  input  logic [DW-1:0]       hb,
  output logic signed [PW-1:0] prod
);
  localparam int HW = DW / 2;

  logic signed [2*DW-1:0] p_full;
  logic signed [2*HW-1:0] p_a, p_b;
  logic signed [2*HW:0]   p_pair;

  always_comb begin
    p_full = $signed(sa) * $signed(ha);
    p_a    = $signed(sa[DW-1:DW-HW]) * $signed(ha[DW-1:DW-HW]);
    p_b    = $signed(sb[DW-1:DW-HW]) * $signed(hb[DW-1:DW-HW]);
    p_pair = PW'(0) + p_a + p_b;
    if (!en)                               prod = '0;
    else if (mode == fir_pkg::MODE_SPLIT)  prod = PW'(p_pair) <<< DW;
    else                                   prod = PW'(p_full);
  end
endmodule

// File: rtl/fir_adder_tree.sv
module fir_adder_tree #(
  parameter int NLEAF = 35,
  parameter int W     = 23
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic signed [W-1:0] leaf [NLEAF],
  output logic                out_vld,
  output logic signed [W-1:0] sum
);
  localparam int LVLS   = $clog2(NLEAF);
  localparam int LEAVES = 1 << LVLS;

  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int N = LEAVES >> l;
    logic signed [W-1:0] node [N];
    logic                vld;

    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < N; i++) begin : g_i
        if (i < NLEAF) begin : g_use
          assign node[i] = leaf[i];
        end else begin : g_pad
          assign node[i] = '0;
        end
      end
      assign vld = in_vld;
    end else begin : g_sum
      logic signed [W-1:0] node_d [N];
      always_comb begin
        for (int i = 0; i < N; i++)
          node_d[i] = g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld <= 1'b0;
          for (int i = 0; i < N; i++) node[i] <= '0;
        end else begin
          vld <= g_lvl[l-1].vld;
          if (g_lvl[l-1].vld) node <= node_d;
        end
      end
    end
  end

  assign sum     = g_lvl[LVLS].node[0];
  assign out_vld = g_lvl[LVLS].vld;
endmodule

// File: rtl/fir_dual_product.sv
module fir_dual_product #(
  parameter int NTAPS = 35,
  parameter int DW    = 8,
  parameter int AW    = $clog2(NTAPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  input  logic          mode,
  input  logic          coef_we,
  input  logic [AW-1:0] coef_addr,
  input  logic [DW-1:0] coef_data,
  output logic          out_valid,
  output logic [DW-1:0] out_sample
);
  import fir_pkg::*;

  localparam int NSLOT = (NTAPS + 1) / 2;
  localparam int PW    = 2*DW + 1;
  localparam int ACCW  = PW + $clog2(NTAPS);
  localparam logic signed [ACCW-1:0] OMAX = ACCW'((1 <<< (DW-1)) - 1);
  localparam logic signed [ACCW-1:0] OMIN = -ACCW'(1 <<< (DW-1));
  localparam logic signed [ACCW:0]   RHALF = (ACCW+1)'(1 <<< (DW-2));

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  mul_mode_e mode_e;
  assign mode_e = mul_mode_e'(mode);

  logic [DW-1:0] taps  [NTAPS];
  logic [DW-1:0] coefs [NTAPS];

  fir_delay_line #(.NTAPS(NTAPS), .DW(DW)) u_line (
    .clk(clk), .rst_n(rst_q), .shift_en(in_valid), .din(in_sample), .taps(taps));

  fir_coef_bank #(.NTAPS(NTAPS), .DW(DW), .AW(AW)) u_coef (
    .clk(clk), .rst_n(rst_q), .we(coef_we), .addr(coef_addr), .wdata(coef_data),
    .coef(coefs));

  // product stage
  logic                   v0;
  logic signed [PW-1:0]   prod_d [NTAPS];
  logic signed [PW-1:0]   prod_q [NTAPS];
  logic signed [ACCW-1:0] leaf   [NTAPS];
  logic                   v1;

  for (genvar k = 0; k < NTAPS; k++) begin : g_lane
    logic [DW-1:0] sa, ha, sb, hb;
    logic          en;
    if (k < NSLOT) begin : g_pair
      localparam int IA = 2*k;
      localparam int IB = 2*k + 1;
      assign sa = (mode_e == MODE_SPLIT) ? taps[IA]  : taps[k];
      assign ha = (mode_e == MODE_SPLIT) ? coefs[IA] : coefs[k];
      assign en = 1'b1;
      if (IB < NTAPS) begin : g_b
        assign sb = taps[IB];
        assign hb = coefs[IB];
      end else begin : g_nob
        assign sb = '0;
        assign hb = '0;
      end
    end else begin : g_solo
      assign sa = taps[k];
      assign ha = coefs[k];
      assign sb = '0;
      assign hb = '0;
      assign en = (mode_e == MODE_WIDE);
    end

    fir_mac_lane #(.DW(DW), .PW(PW)) u_lane (
      .mode(mode_e), .en(en), .sa(sa), .ha(ha), .sb(sb), .hb(hb), .prod(prod_d[k]));

    assign leaf[k] = ACCW'(prod_q[k]);

    if (k >= NSLOT) begin : g_chk
      // R7: lanes beyond the paired range stay silent in split mode
      a_r7_idle_lane_zero: assert property (@(posedge clk) disable iff (!rst_q)
        (v0 && mode_e == MODE_SPLIT) |=> prod_q[k] == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      v0 <= 1'b0;
      v1 <= 1'b0;
      for (int k = 0; k < NTAPS; k++) prod_q[k] <= '0;
    end else begin
      v0 <= in_valid;
      v1 <= v0;
      if (v0) prod_q <= prod_d;
    end
  end

  logic                   t_vld;
  logic signed [ACCW-1:0] t_sum;

  fir_adder_tree #(.NLEAF(NTAPS), .W(ACCW)) u_tree (
    .clk(clk), .rst_n(rst_q), .in_vld(v1), .leaf(leaf), .out_vld(t_vld), .sum(t_sum));

  // round and saturate
  logic signed [ACCW:0]   rnd;
  logic signed [ACCW:0]   shr;
  logic        [DW-1:0]   out_d;
  logic        [DW-1:0]   out_q;
  logic                   ovld_q;

  always_comb begin
    rnd = (ACCW+1)'(t_sum) + RHALF;
    shr = rnd >>> (DW-1);
    if (shr > (ACCW+1)'(OMAX))      out_d = OMAX[DW-1:0];
    else if (shr < (ACCW+1)'(OMIN)) out_d = OMIN[DW-1:0];
    else                            out_d = shr[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_q  <= '0;
      ovld_q <= 1'b0;
    end else begin
      ovld_q <= t_vld;
      if (t_vld) out_q <= out_d;
    end
  end

  assign out_valid  = ovld_q;
  assign out_sample = out_q;

  // R9: sums past the positive and negative limits pin the output
  a_r9_sat_high: assert property (@(posedge clk) disable iff (!rst_q)
    (t_vld && t_sum >= ACCW'((((1 <<< (DW-1)) - 1) <<< (DW-1)) + (1 <<< (DW-2))))
    |=> out_sample == OMAX[DW-1:0]);
  a_r9_sat_low: assert property (@(posedge clk) disable iff (!rst_q)
    (t_vld && t_sum < -ACCW'((1 <<< (2*DW-2)) + (1 <<< (DW-2))))
    |=> out_sample == OMIN[DW-1:0]);
  // R4: a result only appears while the pipeline carries one
  a_r4_valid_from_tree: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> $past(t_vld));
endmodule

// File: tb/fir_dual_product_tb.sv
module fir_dual_product_tb;
  localparam int NT = 35;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_sample;
  logic       mode;
  logic       coef_we;
  logic [5:0] coef_addr;
  logic [7:0] coef_data;
  logic       out_valid;
  logic [7:0] out_sample;

  always #10 clk = ~clk;

  fir_dual_product u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample), .mode(mode),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .out_valid(out_valid), .out_sample(out_sample));

  int    n_checks = 0;
  int    n_fail   = 0;
  int    coef [NT];
  int    hist [NT];
  int    exp_q [$];
  string tag_q [$];
  string cur_tag = "R6";
  bit    done = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_out();
    longint acc = 0;
    longint r;
    for (int i = 0; i < NT; i++) begin
      if (mode) acc += longint'((coef[i] >>> 4) * (hist[i] >>> 4)) * 256;
      else      acc += longint'(coef[i] * hist[i]);
    end
    r = (acc + 64) >>> 7;
    if (r > 127)  r = 127;
    if (r < -128) r = -128;
    return int'(r);
  endfunction

  task automatic send(input int s);
    @(negedge clk);
    coef_we   = 1'b0;
    in_valid  = 1'b1;
    in_sample = s[7:0];
    for (int i = NT-1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = int'($signed(s[7:0]));
    exp_q.push_back(model_out());
    tag_q.push_back(cur_tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      coef_we  = 1'b0;
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    in_valid  = 1'b0;
    coef_we   = 1'b1;
    coef_addr = a[5:0];
    coef_data = d[7:0];
    if (a < NT) coef[a] = int'($signed(d[7:0]));
  endtask

  task automatic flush(input string tag);
    idle(14);
    check(tag, exp_q.size(), 0);
  endtask

  // scoreboard: every result is compared in order with the model
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (exp_q.size() == 0) begin
        check("R4", 1, 0);
      end else begin
        check(tag_q.pop_front(), int'($signed(out_sample)), exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    for (int i = 0; i < NT; i++) begin coef[i] = 0; hist[i] = 0; end
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; mode = 1'b0;
    coef_we = 1'b0; coef_addr = '0; coef_data = '0;
    repeat (4) @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_sample), 0);
    rst_n = 1'b1;
    idle(4);
    check("R1", int'(out_valid), 0);

    // R1: all coefficients zero after reset
    cur_tag = "R1";
    for (int v = 0; v < 20; v++) send(v * 13 - 100);
    flush("R1");

    // R1/R2: load taps, first outputs see zero history
    for (int i = 0; i < NT; i++) wr(i, ((i * 53 + 11) % 256) - 128);
    idle(1);
    cur_tag = "R2";
    send(100); send(-77); send(5);
    flush("R2");

    // R5: latency from the accepting edge
    send(64);
    cnt = 0;
    do begin
      @(negedge clk);
      in_valid = 1'b0;
      cnt++;
    end while (!out_valid && cnt < 30);
    check("R5", cnt, 9);
    flush("R5");

    // R6: full sweep of sample values in wide mode
    cur_tag = "R6";
    for (int v = 0; v < 256; v++) send(((v * 97) % 256) - 128);
    flush("R6");

    // R4: idle gaps must not shift the line
    cur_tag = "R4";
    for (int v = 0; v < 60; v++) begin
      send(v * 29 - 90);
      if (v % 3 == 0) idle(2);
    end
    flush("R4");

    // R3: out-of-range writes change nothing
    for (int a = NT; a < 64; a++) wr(a, 127);
    idle(1);
    cur_tag = "R3";
    for (int v = 0; v < 50; v++) send(v * 41 - 120);
    flush("R3");

    // R7: split mode sweep with two coefficient sets
    mode = 1'b1;
    idle(2);
    cur_tag = "R7";
    for (int v = 0; v < 256; v++) send(((v * 61) % 256) - 128);
    flush("R7");
    for (int i = 0; i < NT; i++) wr(i, (i % 2 == 0) ? 120 - i : -100 + 3 * i);
    wr(34, -128);
    idle(1);
    for (int v = 0; v < 256; v++) send(v - 128);
    flush("R7");
    // tap 34 alone (its partner is absent)
    for (int i = 0; i < NT; i++) wr(i, 0);
    wr(34, 112);
    idle(1);
    for (int v = 0; v < 40; v++) send(v * 7 - 128);
    flush("R7");

    // R8: rounding around the half step, wide mode
    mode = 1'b0;
    wr(34, 0);
    wr(0, 1);
    idle(2);
    cur_tag = "R8";
    send(63); send(64); send(-64); send(-65); send(127); send(-128); send(-1);
    flush("R8");

    // R9: saturation at both ends and extreme sums
    for (int i = 0; i < NT; i++) wr(i, 127);
    idle(1);
    cur_tag = "R9";
    for (int v = 0; v < NT; v++) send(127);
    for (int v = 0; v < NT; v++) send(-128);
    flush("R9");
    for (int i = 0; i < NT; i++) wr(i, -128);
    idle(1);
    for (int v = 0; v < NT; v++) send(-128);
    for (int v = 0; v < NT; v++) send(127);
    flush("R9");
    mode = 1'b1;
    idle(2);
    for (int v = 0; v < NT; v++) send(-128);
    flush("R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule